// File: doc/BRIEF.md
# Pixel Stream Word Packer

This block sits on the write path of an image capture pipeline. It takes a raw sensor stream of one 12-bit pixel per pixel clock, qualified by a frame-valid and a line-valid flag that change on the same clock edge as the data. It gathers the pixels into 64-bit words for a downstream write FIFO and raises a one-cycle strobe with each finished word.

A mode input picks one of two storage formats for each frame. In the compact format each pixel is cut to its eight most significant bits, so eight pixels fill one word. In the wide format each pixel is zero-extended to sixteen bits, so four pixels fill one word. The block follows the frame-valid edges. At the start of a frame it takes the mode and clears its lane position. At the end of a frame it pushes out any partly filled word, then pulses a frame-done flag that the memory side can use to start a burst write request.

Top module: `pixel_word_packer`

## Requirements
- R1: While reset is held and on the first cycle after it, `word_valid_o` and `frame_done_o` are 0 and `word_o` is all zeros.
- R2: A pixel is taken in only on a clock edge where `frame_valid_i` and `line_valid_i` are both 1. On every other edge `pixel_i` is ignored: it produces no word and changes the contents of no later word.
- R3: In compact mode (`wide_mode_i` = 0) the lane value is `pixel_i[11:4]`. The low four bits are dropped, and a word is finished on every eighth accepted pixel.
- R4: In wide mode (`wide_mode_i` = 1) the lane value is `{4'b0, pixel_i}`, and a word is finished on every fourth accepted pixel.
- R5: The first accepted pixel of a word fills the lowest lane: bits 7:0 in compact mode, bits 15:0 in wide mode. Later pixels fill the next higher lanes in order.
- R6: `word_valid_o` is high for exactly one cycle, the cycle after the edge that completed the word. `word_o` holds the last emitted word until the next strobe.
- R7: The mode is sampled only on the edge where `frame_valid_i` is first seen high. That edge also resets the lane position. A change of `wide_mode_i` during a frame has no effect until the next frame.
- R8: If a word is partly filled on the first edge where `frame_valid_i` is seen low, that word is emitted in the next cycle with its unfilled lanes zero.
- R9: `frame_done_o` is a one-cycle pulse once per frame. It comes one cycle after a flush word, or in the cycle after the falling frame-valid edge when there was nothing to flush. It is never high together with `word_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low reset |
| frame_valid_i | input | 1 | High for the whole frame |
| line_valid_i | input | 1 | High while a line's pixels are present |
| pixel_i | input | PIX_W (12) | Pixel sample |
| wide_mode_i | input | 1 | 0 = compact 8-bit lanes, 1 = zero-extended 16-bit lanes |
| word_o | output | WORD_W (64) | Last packed word |
| word_valid_o | output | 1 | One-cycle strobe for a new `word_o` |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
Every output is registered once after the input sample. A completed word therefore shows in the cycle after the edge that took its last pixel. A flush word shows in the cycle after the edge where frame-valid is first seen low, and frame-done follows one cycle after that flush, or at the flush slot itself when nothing was pending. The bench sets inputs just after each rising edge. Two nanoseconds after the next edge it steps a queue-based model with the same inputs and compares all three outputs, so each expected value lines up with the single register stage. Extra checks count words and done pulses per frame and inspect lane contents.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic {
        PK_COMPACT = 1'b0,
        PK_WIDE    = 1'b1
    } pack_mode_e;

    typedef struct packed {
        logic       fv_seen;
        pack_mode_e mode;
    } trk_state_t;

endpackage

// File: rtl/pw_frame_tracker.sv
module pw_frame_tracker
    import pw_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       frame_valid_i,
    input  logic       line_valid_i,
    input  logic       wide_mode_i,
    output logic       sof_o,
    output logic       eof_o,
    output logic       accept_o,
    output pack_mode_e mode_o
);

    trk_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        sof_o    = frame_valid_i & ~st_q.fv_seen;
        eof_o    = ~frame_valid_i & st_q.fv_seen;
        accept_o = frame_valid_i & line_valid_i;
        st_d.fv_seen = frame_valid_i;
        if (sof_o) begin
            st_d.mode = pack_mode_e'(wide_mode_i);
        end
        mode_o = st_d.mode;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{fv_seen: 1'b0, mode: PK_COMPACT};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pw_lane_packer.sv
module pw_lane_packer
    import pw_pkg::*;
#(
    parameter int PIX_W    = 12,
    parameter int WORD_W   = 64,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sof_i,
    input  logic              eof_i,
    input  logic              accept_i,
    input  pack_mode_e        mode_i,
    input  logic [PIX_W-1:0]  pixel_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    output logic              frame_done_o
);

    localparam int NARROW_LANES = WORD_W / NARROW_W;
    localparam int WIDE_LANES   = WORD_W / WIDE_W;
    localparam int LANE_W       = $clog2(NARROW_LANES);
    localparam logic [LANE_W-1:0] NARROW_LAST = LANE_W'(NARROW_LANES - 1);
    localparam logic [LANE_W-1:0] WIDE_LAST   = LANE_W'(WIDE_LANES - 1);

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] word;
        logic              wv;
        logic              pend;
        logic              done;
    } pk_state_t;

    pk_state_t st_d, st_q;

    logic [NARROW_W-1:0] narrow_val;
    logic [WIDE_W-1:0]   wide_val;
    logic [LANE_W-1:0]   lane_base;
    logic [LANE_W-1:0]   lane_last;
    logic [WORD_W-1:0]   acc_base;
    logic [WORD_W-1:0]   acc_new;

    assign narrow_val = pixel_i[PIX_W-1 -: NARROW_W];
    assign wide_val   = WIDE_W'(pixel_i);

    always_comb begin
        st_d      = st_q;
        st_d.wv   = 1'b0;
        st_d.pend = 1'b0;
        st_d.done = st_q.pend;

        lane_base = sof_i ? '0 : st_q.lane;
        acc_base  = sof_i ? '0 : st_q.acc;
        lane_last = (mode_i == PK_WIDE) ? WIDE_LAST : NARROW_LAST;

        acc_new = acc_base;
        if (mode_i == PK_WIDE) begin
            acc_new[lane_base*WIDE_W +: WIDE_W] = wide_val;
        end else begin
            acc_new[lane_base*NARROW_W +: NARROW_W] = narrow_val;
        end

        if (accept_i) begin
            if (lane_base == lane_last) begin
                st_d.word = acc_new;
                st_d.wv   = 1'b1;
                st_d.lane = '0;
                st_d.acc  = '0;
            end else begin
                st_d.lane = lane_base + 1'b1;
                st_d.acc  = acc_new;
            end
        end else if (eof_i) begin
            if (st_q.lane != '0) begin
                st_d.word = st_q.acc;
                st_d.wv   = 1'b1;
                st_d.pend = 1'b1;
            end else begin
                st_d.done = 1'b1;
            end
            st_d.lane = '0;
            st_d.acc  = '0;
        end else if (sof_i) begin
            st_d.lane = '0;
            st_d.acc  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o       = st_q.word;
    assign word_valid_o = st_q.wv;
    assign frame_done_o = st_q.done;

endmodule

// File: rtl/pixel_word_packer.sv
module pixel_word_packer
    import pw_pkg::*;
#(
    parameter int PIX_W    = 12,
    parameter int WORD_W   = 64,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frame_valid_i,
    input  logic              line_valid_i,
    input  logic [PIX_W-1:0]  pixel_i,
    input  logic              wide_mode_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    output logic              frame_done_o
);

    logic       sof, eof, accept;
    pack_mode_e mode_eff;

    pw_frame_tracker u_track (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .frame_valid_i (frame_valid_i),
        .line_valid_i  (line_valid_i),
        .wide_mode_i   (wide_mode_i),
        .sof_o         (sof),
        .eof_o         (eof),
        .accept_o      (accept),
        .mode_o        (mode_eff)
    );

    pw_lane_packer #(
        .PIX_W    (PIX_W),
        .WORD_W   (WORD_W),
        .NARROW_W (NARROW_W),
        .WIDE_W   (WIDE_W)
    ) u_pack (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sof_i        (sof),
        .eof_i        (eof),
        .accept_i     (accept),
        .mode_i       (mode_eff),
        .pixel_i      (pixel_i),
        .word_o       (word_o),
        .word_valid_o (word_valid_o),
        .frame_done_o (frame_done_o)
    );

endmodule

// File: rtl/pixel_word_packer_chk.sv
module pixel_word_packer_chk #(
    parameter int PIX_W  = 12,
    parameter int WORD_W = 64,
    parameter int WIDE_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              frame_valid_i,
    input logic              wide_mode_i,
    input logic [WORD_W-1:0] word_o,
    input logic              word_valid_o,
    input logic              frame_done_o
);

    localparam int PAD_W = WIDE_W - PIX_W;

    function automatic logic [WORD_W-1:0] pad_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int k = 0; k < WORD_W / WIDE_W; k++) begin
            m[k*WIDE_W + PIX_W +: PAD_W] = '1;
        end
        return m;
    endfunction

    localparam logic [WORD_W-1:0] PAD_MASK = pad_mask();

    logic fv_prev_q, wide_frame_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fv_prev_q    <= 1'b0;
            wide_frame_q <= 1'b0;
        end else begin
            fv_prev_q <= frame_valid_i;
            if (frame_valid_i && !fv_prev_q) begin
                wide_frame_q <= wide_mode_i;
            end
        end
    end

    p_word_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_valid_o |=> !word_valid_o);

    p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |=> !frame_done_o);

    p_done_not_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |-> !word_valid_o);

    p_wide_zero_pad_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_valid_o && wide_frame_q) |-> ((word_o & PAD_MASK) == '0));

    p_end_reaction_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fv_prev_q && !frame_valid_i) |=> (word_valid_o || frame_done_o));

endmodule

bind pixel_word_packer pixel_word_packer_chk #(
    .PIX_W  (PIX_W),
    .WORD_W (WORD_W),
    .WIDE_W (WIDE_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_valid_i (frame_valid_i),
    .wide_mode_i   (wide_mode_i),
    .word_o        (word_o),
    .word_valid_o  (word_valid_o),
    .frame_done_o  (frame_done_o)
);

// File: tb/sim_pixel_word_packer.sv
module sim_pixel_word_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fv = 1'b0, lv = 1'b0, md = 1'b0;
    logic [11:0] pix = '0;
    logic [63:0] word;
    logic        wv, done;

    int checks = 0, failures = 0;
    int word_cnt = 0, done_cnt = 0;
    logic [63:0] last_word;
    string cur_req = "R3";
    bit finished = 0;

    // behavioural reference model state
    bit          m_fv_prev = 0, m_wide = 0, m_pend = 0;
    logic [15:0] m_q[$];
    logic [63:0] e_word = '0;
    bit          e_wv = 0, e_done = 0;

    always #4 clk = ~clk;

    pixel_word_packer u0 (
        .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(fv), .line_valid_i(lv),
        .pixel_i(pix), .wide_mode_i(md), .word_o(word), .word_valid_o(wv),
        .frame_done_o(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] build_word();
        logic [63:0] w = '0;
        int lw = m_wide ? 16 : 8;
        foreach (m_q[i]) w |= 64'(m_q[i]) << (i * lw);
        return w;
    endfunction

    task automatic model_step();
        bit nd = m_pend;
        m_pend = 0;
        e_wv = 0;
        if (fv && !m_fv_prev) begin
            m_wide = md;
            m_q.delete();
        end
        if (fv && lv) begin
            m_q.push_back(m_wide ? {4'b0, pix} : {8'b0, pix[11:4]});
            if (m_q.size() == (m_wide ? 4 : 8)) begin
                e_word = build_word(); e_wv = 1; m_q.delete();
            end
        end else if (!fv && m_fv_prev) begin
            if (m_q.size() > 0) begin
                e_word = build_word(); e_wv = 1; m_pend = 1; m_q.delete();
            end else nd = 1;
        end
        e_done = nd;
        m_fv_prev = fv;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        model_step();
        check(wv === e_wv, "R6", 64'(wv), 64'(e_wv));
        check(done === e_done, "R9", 64'(done), 64'(e_done));
        check(word === e_word, cur_req, word, e_word);
        if (wv) begin word_cnt++; last_word = word; end
        if (done) done_cnt++;
    endtask

    task automatic drive(input logic f, input logic l, input logic [11:0] p);
        fv = f; lv = l; pix = p;
        tick();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [11:0] first_pix;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check(wv === 1'b0 && done === 1'b0, "R1", {62'b0, wv, done}, 64'd0);
        check(word === 64'd0, "R1", word, 64'd0);
        rst_n = 1'b1;
        tick();
        check(word === 64'd0 && !wv, "R1", word, 64'd0);

        // R2: line valid without frame valid is ignored
        cur_req = "R2";
        word_cnt = 0; done_cnt = 0;
        for (int i = 0; i < 10; i++) drive(1'b0, 1'b1, 12'hFFF - 12'(i));
        check(word_cnt == 0 && done_cnt == 0, "R2", 64'(word_cnt), 64'd0);

        // R3 / R5 / R2: compact frame, two lines of eight with gaps
        cur_req = "R3";
        md = 1'b0; word_cnt = 0; done_cnt = 0;
        first_pix = 12'hA5C;
        drive(1'b1, 1'b0, 12'h123);
        drive(1'b1, 1'b0, 12'h456);
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, 1'b1, first_pix + 12'(i * 37));
            if (i == 7) check(word[7:0] == first_pix[11:4], "R5", 64'(word[7:0]), 64'(first_pix[11:4]));
        end
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 12'hEEE);
        for (int i = 0; i < 8; i++) drive(1'b1, 1'b1, 12'h0F0 + 12'(i * 91));
        drive(1'b0, 1'b0, 12'h000);
        drive(1'b0, 1'b0, 12'h000);
        check(word_cnt == 2, "R3", 64'(word_cnt), 64'd2);
        check(done_cnt == 1, "R9", 64'(done_cnt), 64'd1);

        // R4 / R8: wide frame of six pixels, two left for the flush
        cur_req = "R4";
        md = 1'b1; word_cnt = 0; done_cnt = 0;
        drive(1'b1, 1'b0, 12'h000);
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b1, 12'hF00 + 12'(i * 13));
        cur_req = "R8";
        drive(1'b0, 1'b0, 12'h000);
        drive(1'b0, 1'b0, 12'h000);
        drive(1'b0, 1'b0, 12'h000);
        check(word_cnt == 2, "R8", 64'(word_cnt), 64'd2);
        check(last_word[63:32] == 32'd0, "R8", last_word, {32'd0, 16'h0F41, 16'h0F34});
        check(last_word[15:0] == 16'h0F34, "R5", 64'(last_word[15:0]), 64'h0F34);
        check(done_cnt == 1, "R9", 64'(done_cnt), 64'd1);

        // R7: mode change in mid-frame has no effect
        cur_req = "R7";
        md = 1'b0; word_cnt = 0;
        drive(1'b1, 1'b0, 12'h000);
        md = 1'b1;
        for (int i = 0; i < 8; i++) drive(1'b1, 1'b1, 12'h800 + 12'(i * 16));
        drive(1'b0, 1'b0, 12'h000);
        drive(1'b0, 1'b0, 12'h000);
        check(word_cnt == 1, "R7", 64'(word_cnt), 64'd1);
        check(last_word == 64'h8786858483828180, "R7", last_word, 64'h8786858483828180);

        // R9: back-to-back frames with a single idle cycle
        cur_req = "R9";
        md = 1'b1; word_cnt = 0; done_cnt = 0;
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, 12'h111 * 12'(i + 1));
        md = 1'b0;
        drive(1'b0, 1'b0, 12'h000);
        drive(1'b1, 1'b1, 12'hABC);
        for (int i = 0; i < 7; i++) drive(1'b1, 1'b1, 12'h321);
        drive(1'b0, 1'b0, 12'h000);
        drive(1'b0, 1'b0, 12'h000);
        drive(1'b0, 1'b0, 12'h000);
        check(word_cnt == 2, "R9", 64'(word_cnt), 64'd2);
        check(done_cnt == 2, "R9", 64'(done_cnt), 64'd2);

        summary();
    end

endmodule